// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block produces the three phases of an IDE programmed-I/O bus cycle: address setup, strobe active and recovery. It serves four drives on two channels. When the host raises a request while the block is idle, the block does the following:

- It latches the target drive, the direction, the register address and the write data.
- It latches the timing for that drive from the timing register inputs.
- It drives the drive's chip select and the address for the setup period.
- It pulses the read or write strobe for the active period.
- It releases the bus for the recovery period before it takes the next request.

Each drive's timing comes from two bytes.

- **Address-timing byte:** a nonlinear 2-bit setup code sits in its top two bits.
- **Strobe-timing byte:** the active count is the high nibble and the recovery count is the low nibble.

Drives 0 and 1 each have their own pair of bytes. Drives 2 and 3 on the second channel share one pair. A revision input selects the later silicon behaviour, in which recovery lasts one clock longer than programmed. On reads, the bus data is captured in the cycle that ends the strobe.

Top module: `pio_strobe_gen`

## Requirements
- R1: The setup phase length is set by bits 7:6 of the selected address-timing byte: 2'b00 gives 4 clocks, 2'b10 gives 3, 2'b01 gives 2 and 2'b11 gives 5. During setup the chip select is asserted and neither strobe is asserted.
- R2: The active phase lasts the high nibble of the strobe-timing byte in clocks. A nibble of 0 gives 16 clocks and a nibble of 1 gives 2 clocks.
- R3: The recovery phase lasts the low nibble of the strobe-timing byte in clocks, where 0 gives 16. When the resulting active length is greater than 3 and the recovery nibble is 1, recovery lasts 2 clocks.
- R4: When the revision input `rev_late` is 1 at the accepting edge, recovery is one clock longer than the length given by R3.
- R5: Drive 0 uses `at_d0`/`rw_d0` and drive 1 uses `at_d1`/`rw_d1`. Drives 2 and 3 both use `at_d23`/`rw_d23`.
- R6: `busy` rises in the cycle after a request is accepted and stays high for exactly setup plus active plus recovery clocks. A request is accepted only while `busy` is low, and a request raised while `busy` is high has no effect.
- R7: `cs_drv[d]` (bit d for drive d) and `ide_addr` are driven through the setup and active phases and are zero in recovery and idle. In the active phase exactly one strobe is asserted: `wr_stb` when `req_wr` was 1, otherwise `rd_stb`. `ide_dout` carries the latched write data.
- R8: For a read, `rd_data` takes the value of `ide_din` at the clock edge that ends the active phase. `rd_valid` is high for exactly one cycle, which is the first recovery cycle. A write produces no `rd_valid`.
- R9: Changes to the timing bytes, to `rev_late` or to the request fields after the accepting edge do not change the cycle in progress.
- R10: After reset, `busy`, `cs_drv`, both strobes and `rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rev_late | input | 1 | Later-revision recovery (+1 clock) |
| at_d0 | input | 8 | Address-timing byte, drive 0 |
| at_d1 | input | 8 | Address-timing byte, drive 1 |
| at_d23 | input | 8 | Address-timing byte shared by drives 2 and 3 |
| rw_d0 | input | 8 | Strobe-timing byte, drive 0 |
| rw_d1 | input | 8 | Strobe-timing byte, drive 1 |
| rw_d23 | input | 8 | Strobe-timing byte shared by drives 2 and 3 |
| req | input | 1 | Host cycle request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_drv | input | 2 | Target drive 0..3 |
| req_addr | input | AW | Task-file register address |
| req_wdata | input | DW | Write data |
| ide_din | input | DW | Data from the drive bus |
| busy | output | 1 | Cycle in progress |
| cs_drv | output | 4 | Per-drive chip select, active high |
| ide_addr | output | AW | Bus address |
| rd_stb | output | 1 | Read strobe, active high |
| wr_stb | output | 1 | Write strobe, active high |
| ide_dout | output | DW | Write data to the bus |
| rd_data | output | DW | Captured read data |
| rd_valid | output | 1 | One-cycle pulse when rd_data is updated |

## Verification
The hardest case to reach from the ports is a cycle in progress whose latched timing differs from what the inputs show at that moment. This case shows whether the block re-reads the timing bytes mid-cycle or accepts a stray request. The bench reaches it in random transactions. At a random point during each busy period it overwrites every timing byte, `rev_late` and the request fields, and pulses `req`. It then checks the measured setup, active and recovery lengths against values computed from the settings captured at the request. Directed transactions cover all four setup codes, the nibble values 0 and 1, and the recovery stretch on both sides of the active-length threshold.

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rev_late,
  input  logic [7:0]    at_d0,
  input  logic [7:0]    at_d1,
  input  logic [7:0]    at_d23,
  input  logic [7:0]    rw_d0,
  input  logic [7:0]    rw_d1,
  input  logic [7:0]    rw_d23,
  input  logic          req,
  input  logic          req_wr,
  input  logic [1:0]    req_drv,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] ide_din,
  output logic          busy,
  output logic [3:0]    cs_drv,
  output logic [AW-1:0] ide_addr,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [DW-1:0] ide_dout,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACT, PH_REC} phase_t;

  phase_t          ph;
  logic [4:0]      cnt;
  logic [4:0]      act_len, rec_len;
  logic [1:0]      drv_q;
  logic            wr_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;

  logic [7:0] at_sel, rw_sel;
  logic [4:0] s_eff, a_eff, r_base, r_eff;
  logic       take, on_bus;

  assign at_sel = (req_drv == 2'd0) ? at_d0 : (req_drv == 2'd1) ? at_d1 : at_d23;
  assign rw_sel = (req_drv == 2'd0) ? rw_d0 : (req_drv == 2'd1) ? rw_d1 : rw_d23;

  always_comb begin
    unique case (at_sel[7:6])
      2'b00:   s_eff = 5'd4;
      2'b10:   s_eff = 5'd3;
      2'b01:   s_eff = 5'd2;
      default: s_eff = 5'd5;
    endcase
  end

  always_comb begin
    if (rw_sel[7:4] == 4'd0)      a_eff = 5'd16;
    else if (rw_sel[7:4] == 4'd1) a_eff = 5'd2;
    else                          a_eff = {1'b0, rw_sel[7:4]};
    if (rw_sel[3:0] == 4'd0)                      r_base = 5'd16;
    else if (rw_sel[3:0] == 4'd1 && a_eff > 5'd3) r_base = 5'd2;
    else                                          r_base = {1'b0, rw_sel[3:0]};
    r_eff = r_base + {4'd0, rev_late};
  end

  assign take   = req && (ph == PH_IDLE);
  assign on_bus = (ph == PH_SETUP) || (ph == PH_ACT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      act_len  <= '0;
      rec_len  <= '0;
      drv_q    <= '0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      unique case (ph)
        PH_IDLE: if (take) begin
          ph      <= PH_SETUP;
          cnt     <= s_eff - 5'd1;
          act_len <= a_eff;
          rec_len <= r_eff;
          drv_q   <= req_drv;
          wr_q    <= req_wr;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
        end
        PH_SETUP: if (cnt == 5'd0) begin
          ph  <= PH_ACT;
          cnt <= act_len - 5'd1;
        end else cnt <= cnt - 5'd1;
        PH_ACT: if (cnt == 5'd0) begin
          ph  <= PH_REC;
          cnt <= rec_len - 5'd1;
          if (!wr_q) begin
            rd_data  <= ide_din;
            rd_valid <= 1'b1;
          end
        end else cnt <= cnt - 5'd1;
        default: if (cnt == 5'd0) ph <= PH_IDLE;
                 else cnt <= cnt - 5'd1;
      endcase
    end
  end

  assign busy     = (ph != PH_IDLE);
  assign cs_drv   = on_bus ? (4'b0001 << drv_q) : 4'b0000;
  assign ide_addr = on_bus ? addr_q : '0;
  assign rd_stb   = (ph == PH_ACT) && !wr_q;
  assign wr_stb   = (ph == PH_ACT) && wr_q;
  assign ide_dout = wdata_q;

  AST_ONE_STROBE:    assert property (@(posedge clk) disable iff (!rst_n) !(rd_stb && wr_stb)); // R7
  AST_CS_ONEHOT0:    assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs_drv)); // R7
  AST_STB_HAS_CS:    assert property (@(posedge clk) disable iff (!rst_n) (rd_stb || wr_stb) |-> $countones(cs_drv) == 1); // R7
  AST_STB_IN_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) (rd_stb || wr_stb || cs_drv != 4'd0) |-> busy); // R6
  AST_ACT_MIN_TWO:   assert property (@(posedge clk) disable iff (!rst_n) $rose(rd_stb || wr_stb) |=> (rd_stb || wr_stb)); // R2
  AST_VALID_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid); // R8
  AST_VALID_AFTER:   assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> $past(rd_stb) && !rd_stb); // R8
  AST_HOLD_TARGET:   assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(drv_q) && $stable(wr_q)); // R9

endmodule

// File: tb/pio_strobe_gen_tb_top.sv
module pio_strobe_gen_tb_top;
  localparam int DW = 16;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rev_late = 1'b0;
  logic [7:0] at_d0 = '0, at_d1 = '0, at_d23 = '0, rw_d0 = '0, rw_d1 = '0, rw_d23 = '0;
  logic req = 1'b0, req_wr = 1'b0;
  logic [1:0] req_drv = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, ide_din = '0;
  logic busy, rd_stb, wr_stb, rd_valid;
  logic [3:0] cs_drv;
  logic [AW-1:0] ide_addr;
  logic [DW-1:0] ide_dout, rd_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pio_strobe_gen #(.DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rev_late(rev_late),
    .at_d0(at_d0), .at_d1(at_d1), .at_d23(at_d23),
    .rw_d0(rw_d0), .rw_d1(rw_d1), .rw_d23(rw_d23),
    .req(req), .req_wr(req_wr), .req_drv(req_drv), .req_addr(req_addr),
    .req_wdata(req_wdata), .ide_din(ide_din), .busy(busy), .cs_drv(cs_drv),
    .ide_addr(ide_addr), .rd_stb(rd_stb), .wr_stb(wr_stb), .ide_dout(ide_dout),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_setup(input logic [7:0] at);
    case (at[7:6])
      2'b00: return 4;
      2'b10: return 3;
      2'b01: return 2;
      default: return 5;
    endcase
  endfunction

  function automatic int exp_act(input logic [7:0] rw);
    if (rw[7:4] == 0) return 16;
    if (rw[7:4] == 1) return 2;
    return int'(rw[7:4]);
  endfunction

  function automatic int exp_rec(input logic [7:0] rw, input bit rev);
    int r;
    r = (rw[3:0] == 0) ? 16 : int'(rw[3:0]);
    if (rw[3:0] == 1 && exp_act(rw) > 3) r = 2;
    return r + (rev ? 1 : 0);
  endfunction

  // One transaction; R5 selection of timing bytes done here by drive number.
  task automatic xfer(input bit wr, input logic [1:0] drv, input logic [AW-1:0] ad,
                      input logic [DW-1:0] wd, input logic [DW-1:0] din, input bit disturb);
    logic [7:0] at, rw;
    int es, ea, er, ms, ma, mr, nval, glitch_k, k;
    bit seen_stb, bad_cs, bad_stb, bad_addr;
    at = (drv == 0) ? at_d0 : (drv == 1) ? at_d1 : at_d23;
    rw = (drv == 0) ? rw_d0 : (drv == 1) ? rw_d1 : rw_d23;
    es = exp_setup(at); ea = exp_act(rw); er = exp_rec(rw, rev_late);
    ms = 0; ma = 0; mr = 0; nval = 0; seen_stb = 0;
    bad_cs = 0; bad_stb = 0; bad_addr = 0;
    glitch_k = disturb ? int'($urandom_range(0, es + ea + er - 1)) : -1;
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_drv = drv; req_addr = ad; req_wdata = wd; ide_din = din;
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, "R6 busy after accept", busy, 1);
    k = 0;
    while (busy && k < 80) begin
      req = 1'b0;
      if (k == glitch_k) begin
        // R9 / R6: disturb every input mid-cycle and raise a stray request
        req = 1'b1; req_wr = ~wr; req_drv = ~drv; req_addr = ~ad;
        req_wdata = $urandom; rev_late = ~rev_late;
        at_d0 = $urandom; at_d1 = $urandom; at_d23 = $urandom;
        rw_d0 = $urandom; rw_d1 = $urandom; rw_d23 = $urandom;
        ide_din = din;
      end
      if (rd_valid) nval++;
      if (rd_stb || wr_stb) begin
        ma++; seen_stb = 1;
        if (rd_stb == wr_stb || wr_stb != wr) bad_stb = 1;
        if (cs_drv != (4'b1 << drv)) bad_cs = 1;
        if (ide_addr != ad) bad_addr = 1;
      end else if (!seen_stb) begin
        ms++;
        if (cs_drv != (4'b1 << drv)) bad_cs = 1;
        if (ide_addr != ad) bad_addr = 1;
      end else begin
        mr++;
        if (cs_drv != 4'd0 || ide_addr != '0) bad_cs = 1;
      end
      if (wr && ide_dout != wd) bad_addr = 1;
      k++;
      @(negedge clk);
    end
    req = 1'b0;
    chk(ms == es, "R1 setup length", ms, es);
    chk(ma == ea, "R2 active length", ma, ea);
    chk(mr == er, "R3/R4 recovery length", mr, er);
    chk(!bad_cs, "R7 chip select placement", bad_cs, 0);
    chk(!bad_stb, "R7 strobe direction", bad_stb, 0);
    chk(!bad_addr, "R7 address/write data", bad_addr, 0);
    chk(nval == (wr ? 0 : 1), "R8 rd_valid count", nval, wr ? 0 : 1);
    if (!wr) chk(rd_data == din, "R8 read data", rd_data, din);
    @(negedge clk);
    chk(busy == 1'b0, "R6 stray request ignored", busy, 0);
  endtask

  task automatic set_all(input logic [7:0] at, input logic [7:0] rw);
    at_d0 = at; at_d1 = at; at_d23 = at; rw_d0 = rw; rw_d1 = rw; rw_d23 = rw;
  endtask

  initial begin
    void'($urandom(32'h1DE5));
    repeat (3) @(negedge clk);
    chk(busy == 0 && cs_drv == 0 && !rd_stb && !wr_stb && !rd_valid, "R10 reset state", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 all setup codes
    rev_late = 0;
    set_all(8'h00, 8'h33); xfer(0, 2'd0, 3'd1, 16'h1111, 16'hA001, 0);
    set_all(8'h80, 8'h33); xfer(1, 2'd1, 3'd2, 16'h2222, 16'hA002, 0);
    set_all(8'h40, 8'h33); xfer(0, 2'd2, 3'd3, 16'h3333, 16'hA003, 0);
    set_all(8'hC0, 8'h33); xfer(1, 2'd3, 3'd4, 16'h4444, 16'hA004, 0);
    // R2 / R3 nibble corners
    set_all(8'h3F, 8'h00); xfer(0, 2'd0, 3'd7, 16'h5555, 16'hBEEF, 0);
    set_all(8'h00, 8'h11); xfer(0, 2'd1, 3'd0, 16'h0, 16'h1234, 0);
    set_all(8'h00, 8'h41); xfer(1, 2'd2, 3'd5, 16'h6666, 16'h0, 0);
    set_all(8'h00, 8'h31); xfer(0, 2'd3, 3'd6, 16'h0, 16'h4321, 0);
    // R4 later revision
    rev_late = 1;
    set_all(8'h80, 8'h52); xfer(0, 2'd0, 3'd2, 16'h0, 16'h7777, 0);
    set_all(8'h80, 8'hF0); xfer(1, 2'd1, 3'd2, 16'h8888, 16'h0, 0);
    // R5 distinct per-drive bytes, shared pair for drives 2 and 3
    rev_late = 0;
    at_d0 = 8'h00; rw_d0 = 8'h23;
    at_d1 = 8'hC0; rw_d1 = 8'h65;
    at_d23 = 8'h40; rw_d23 = 8'h92;
    xfer(0, 2'd0, 3'd1, 16'h0, 16'h0101, 0);
    xfer(0, 2'd1, 3'd1, 16'h0, 16'h0202, 0);
    xfer(1, 2'd2, 3'd1, 16'h0303, 16'h0, 0);
    xfer(0, 2'd3, 3'd1, 16'h0, 16'h0404, 0);
    // random with mid-cycle disturbance (R6, R9)
    for (int i = 0; i < 60; i++) begin
      rev_late = $urandom_range(0, 1);
      at_d0 = $urandom; at_d1 = $urandom; at_d23 = $urandom;
      rw_d0 = $urandom; rw_d1 = $urandom; rw_d23 = $urandom;
      xfer($urandom_range(0, 1), 2'($urandom_range(0, 3)), AW'($urandom),
           16'($urandom), 16'($urandom), 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule